// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is one programmable logic cell of a small complex programmable logic device. It takes product-term values that an AND array outside the block has already formed. Static configuration inputs decide how those terms are used. Some terms are summed in an OR gate, and that sum can be widened by a cascade input from a neighbouring cell. The sum then passes through an XOR gate that can invert it or mix in one more term. The result goes to a storage element, to the pin, or to both.

The storage element can act as a D, T, JK or SR flip-flop, or as a latch that is transparent while its clock is high. Its clock comes from one of the global clocks or from a product term. When a global clock is in use, a product term can serve as a clock enable. Asynchronous clear and set each have their own selectable source. The pin output and the buried feedback to the routing fabric each choose, independently, between the stored value and the combinational value. The cell also drives a foldback term, which is the inverse of one chosen product term. The pin output enable is taken from one of two global enable inputs, optionally inverted.

The configuration inputs are meant to be held constant while the cell runs. Each product-term index field selects bit `pt_in[index]`; an index at or above the number of terms reads as 0.

Top module: `mc_cell`

## Requirements
- R1: `cas_out` is the OR of every `pt_in[k]` whose `cfg_or_mask[k]` is 1, ORed with `cas_in` when `cfg_cas_en` is 1. Terms whose mask bit is 0 add nothing to the sum, and `cas_in` adds nothing while `cfg_cas_en` is 0.
- R2: The combinational value is `cas_out` XOR a polarity operand. The operand is set by `cfg_xor_sel`: 0 gives constant 0, 1 gives constant 1, 2 gives `pt_in[cfg_xor_pt]`.
- R3: The storage data input is set by `cfg_dsrc`: 0 gives the combinational value, 1 gives `pt_in[cfg_dpt]`, 2 gives `pin_in`.
- R4: `cfg_mode` sets the storage behaviour on a rising clock edge. 0 is D (load the data). 1 is T (toggle when the data is 1). 2 is JK, with J the data input and K = `pt_in[cfg_dpt]`. 3 is SR, with S the data input and R = `pt_in[cfg_dpt]`; when S and R are both 1 the result is 0.
- R5: With `cfg_mode` = 4 the element is a latch. It follows the data input while the selected clock is high and holds its value while the clock is low.
- R6: `cfg_clk_sel` values 0 to 2 pick `gclk[0]` to `gclk[2]`, and value 3 picks `pt_in[cfg_clk_pt]`. Edges on clocks that are not selected have no effect.
- R7: When `cfg_ce_en` is 1 and a global clock is selected, rising edges are ignored while `pt_in[cfg_ce_pt]` is 0. With a product-term clock the enable has no effect.
- R8: Asynchronous clear forces the stored value to 0 at once. `cfg_ar_sel` sets its source: 0 is none, 1 is `gclr`, 2 is `pt_in[cfg_ar_pt]`, 3 is either of the two. After a clear, a registered pin output reads 0.
- R9: When `cfg_ap_en` is 1, `pt_in[cfg_ap_pt]` sets the stored value to 1 at once. If clear and set are active together, clear wins.
- R10: `pin_out` is the stored value when `cfg_pin_reg` is 1 and the combinational value otherwise. `fb_out` makes the same choice independently, using `cfg_fb_reg`.
- R11: `fold_out` is the inverse of `pt_in[cfg_fold_pt]`.
- R12: `pin_oe` is `goe[cfg_oe_pin]`, inverted when `cfg_oe_inv` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_in | input | NUM_PT | Product-term values from the AND array |
| cas_in | input | 1 | Sum from the neighbouring cell |
| gclk | input | NUM_GCLK | Global clocks |
| gclr | input | 1 | Global asynchronous clear |
| goe | input | 2 | Global output-enable inputs |
| pin_in | input | 1 | Value read back from the pin |
| cfg_or_mask | input | NUM_PT | Selects which terms are summed in the OR gate |
| cfg_cas_en | input | 1 | Adds the cascade input to the sum |
| cfg_xor_sel | input | 2 | Selects the polarity operand |
| cfg_xor_pt | input | IW | Term index for the polarity operand |
| cfg_dsrc | input | 2 | Selects the storage data source |
| cfg_dpt | input | IW | Term index for data, K or R |
| cfg_mode | input | 3 | Storage mode |
| cfg_clk_sel | input | CSW | Clock source |
| cfg_clk_pt | input | IW | Term index for the product-term clock |
| cfg_ce_en | input | 1 | Turns on the clock enable |
| cfg_ce_pt | input | IW | Term index for the clock enable |
| cfg_ar_sel | input | 2 | Clear source |
| cfg_ar_pt | input | IW | Term index for the clear |
| cfg_ap_en | input | 1 | Turns on the set |
| cfg_ap_pt | input | IW | Term index for the set |
| cfg_pin_reg | input | 1 | Pin output registered (1) or combinational (0) |
| cfg_fb_reg | input | 1 | Feedback registered (1) or combinational (0) |
| cfg_fold_pt | input | IW | Term index for the foldback |
| cfg_oe_pin | input | 1 | Which global enable drives the pin |
| cfg_oe_inv | input | 1 | Inverts the output enable |
| cas_out | output | 1 | OR sum sent on to the next cell |
| fold_out | output | 1 | Inverted foldback term |
| fb_out | output | 1 | Buried feedback |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |

## Verification
A wrong stored value shows on `pin_out` or `fb_out` only when those outputs are registered. It appears right after the clock edge that loaded it, or at once when an asynchronous clear or set is applied. A faulty mode decode, such as a JK toggle treated as a hold, stays invisible until the first edge where the data and K inputs both matter. The bench therefore drives every corner of each mode table and reads the registered pin after each single edge. A clock or enable mux that picks the wrong source shows up as a value that changes when a clock that should be ignored ticks, or that fails to change on the one edge that counts.

// File: rtl/mc_pkg.sv
package mc_pkg;

   // operand fed to the second XOR input
   typedef enum logic [1:0] {
      XP_ZERO = 2'd0,
      XP_ONE  = 2'd1,
      XP_TERM = 2'd2
   } xpol_e;

   // storage data source
   typedef enum logic [1:0] {
      DS_XOR  = 2'd0,
      DS_TERM = 2'd1,
      DS_PIN  = 2'd2
   } dsrc_e;

   // storage behaviour
   typedef enum logic [2:0] {
      MODE_D     = 3'd0,
      MODE_T     = 3'd1,
      MODE_JK    = 3'd2,
      MODE_SR    = 3'd3,
      MODE_LATCH = 3'd4
   } mode_e;

   // clear source; bit 0 = global clear, bit 1 = product term
   typedef enum logic [1:0] {
      AR_NONE   = 2'd0,
      AR_GLOBAL = 2'd1,
      AR_TERM   = 2'd2,
      AR_EITHER = 2'd3
   } arsel_e;

endpackage

// File: rtl/mc_steer.sv
module mc_steer
   import mc_pkg::*;
#(
   parameter int NUM_PT      = 5,
   parameter bit HAS_CASCADE = 1'b1,
   localparam int IW         = $clog2(NUM_PT)
) (
   input  logic [NUM_PT-1:0] pt_in,
   input  logic              cas_in,
   input  logic              pin_in,
   input  logic [NUM_PT-1:0] cfg_or_mask,
   input  logic              cfg_cas_en,
   input  logic [1:0]        cfg_xor_sel,
   input  logic [IW-1:0]     cfg_xor_pt,
   input  logic [1:0]        cfg_dsrc,
   input  logic [IW-1:0]     cfg_dpt,
   input  logic [IW-1:0]     cfg_fold_pt,
   output logic              or_sum,
   output logic              comb_val,
   output logic              d_val,
   output logic              k_val,
   output logic              fold_val
);

   function automatic logic pick(input logic [NUM_PT-1:0] v, input logic [IW-1:0] i);
      return (int'(i) < NUM_PT) ? v[i] : 1'b0;
   endfunction

   logic [NUM_PT-1:0] steered;
   logic              cas_term;
   logic              xor_op;

   // only terms routed to the OR reach the sum; all others read 0
   for (genvar k = 0; k < NUM_PT; k++) begin : g_steer
      assign steered[k] = pt_in[k] & cfg_or_mask[k];
   end

   if (HAS_CASCADE) begin : g_cas
      assign cas_term = cfg_cas_en & cas_in;
   end else begin : g_nocas
      assign cas_term = 1'b0;
   end

   assign or_sum = (|steered) | cas_term;

   always_comb begin
      case (xpol_e'(cfg_xor_sel))
         XP_ZERO: xor_op = 1'b0;
         XP_ONE:  xor_op = 1'b1;
         XP_TERM: xor_op = pick(pt_in, cfg_xor_pt);
         default: xor_op = 1'b0;
      endcase
   end

   assign comb_val = or_sum ^ xor_op;

   always_comb begin
      case (dsrc_e'(cfg_dsrc))
         DS_XOR:  d_val = comb_val;
         DS_TERM: d_val = pick(pt_in, cfg_dpt);
         DS_PIN:  d_val = pin_in;
         default: d_val = comb_val;
      endcase
   end

   assign k_val    = pick(pt_in, cfg_dpt);
   assign fold_val = ~pick(pt_in, cfg_fold_pt);

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
   import mc_pkg::*;
#(
   parameter int NUM_PT   = 5,
   parameter int NUM_GCLK = 3,
   localparam int IW      = $clog2(NUM_PT),
   localparam int CSW     = $clog2(NUM_GCLK + 1)
) (
   input  logic [NUM_PT-1:0]   pt_in,
   input  logic [NUM_GCLK-1:0] gclk,
   input  logic                gclr,
   input  logic [CSW-1:0]      cfg_clk_sel,
   input  logic [IW-1:0]       cfg_clk_pt,
   input  logic                cfg_ce_en,
   input  logic [IW-1:0]       cfg_ce_pt,
   input  logic [1:0]          cfg_ar_sel,
   input  logic [IW-1:0]       cfg_ar_pt,
   input  logic                cfg_ap_en,
   input  logic [IW-1:0]       cfg_ap_pt,
   output logic                st_clk,
   output logic                st_ce,
   output logic                st_arst,
   output logic                st_apre
);

   function automatic logic pick(input logic [NUM_PT-1:0] v, input logic [IW-1:0] i);
      return (int'(i) < NUM_PT) ? v[i] : 1'b0;
   endfunction

   logic use_global;

   assign use_global = int'(cfg_clk_sel) < NUM_GCLK;

   always_comb begin
      if (use_global) st_clk = gclk[cfg_clk_sel];
      else            st_clk = pick(pt_in, cfg_clk_pt);
   end

   // the enable term gates global clocks only
   assign st_ce = (cfg_ce_en && use_global) ? pick(pt_in, cfg_ce_pt) : 1'b1;

   assign st_arst = (cfg_ar_sel[0] & gclr) | (cfg_ar_sel[1] & pick(pt_in, cfg_ar_pt));
   assign st_apre = cfg_ap_en & pick(pt_in, cfg_ap_pt);

endmodule

// File: rtl/mc_store.sv
module mc_store
   import mc_pkg::*;
(
   input  logic       st_clk,
   input  logic       st_ce,
   input  logic       st_arst,
   input  logic       st_apre,
   input  logic [2:0] cfg_mode,
   input  logic       d_val,
   input  logic       k_val,
   output logic       st_q
);

   logic q_ff;
   logic q_lat;
   logic nxt;

   always_comb begin
      case (mode_e'(cfg_mode))
         MODE_D:  nxt = d_val;
         MODE_T:  nxt = q_ff ^ d_val;
         MODE_JK: nxt = (d_val & ~q_ff) | (~k_val & q_ff);
         MODE_SR: nxt = k_val ? 1'b0 : (d_val ? 1'b1 : q_ff);
         default: nxt = q_ff;
      endcase
   end

   // clear is tested first, so it dominates the set
   always_ff @(posedge st_clk or posedge st_arst or posedge st_apre) begin
      if (st_arst)      q_ff <= 1'b0;
      else if (st_apre) q_ff <= 1'b1;
      else if (st_ce)   q_ff <= nxt;
   end

   always_latch begin
      if (st_arst)      q_lat = 1'b0;
      else if (st_apre) q_lat = 1'b1;
      else if (st_clk)  q_lat = d_val;
   end

   assign st_q = (mode_e'(cfg_mode) == MODE_LATCH) ? q_lat : q_ff;

   // R9
   always @(posedge st_clk) begin
      if (st_arst === 1'b1) begin
         reset_wins_chk: assert (st_q == 1'b0)
            else $error("stored value not cleared while clear is active");
      end
   end

endmodule

// File: rtl/mc_cell.sv
module mc_cell
   import mc_pkg::*;
#(
   parameter int NUM_PT      = 5,
   parameter int NUM_GCLK    = 3,
   parameter bit HAS_CASCADE = 1'b1,
   localparam int IW         = $clog2(NUM_PT),
   localparam int CSW        = $clog2(NUM_GCLK + 1)
) (
   input  logic [NUM_PT-1:0]   pt_in,
   input  logic                cas_in,
   input  logic [NUM_GCLK-1:0] gclk,
   input  logic                gclr,
   input  logic [1:0]          goe,
   input  logic                pin_in,
   input  logic [NUM_PT-1:0]   cfg_or_mask,
   input  logic                cfg_cas_en,
   input  logic [1:0]          cfg_xor_sel,
   input  logic [IW-1:0]       cfg_xor_pt,
   input  logic [1:0]          cfg_dsrc,
   input  logic [IW-1:0]       cfg_dpt,
   input  logic [2:0]          cfg_mode,
   input  logic [CSW-1:0]      cfg_clk_sel,
   input  logic [IW-1:0]       cfg_clk_pt,
   input  logic                cfg_ce_en,
   input  logic [IW-1:0]       cfg_ce_pt,
   input  logic [1:0]          cfg_ar_sel,
   input  logic [IW-1:0]       cfg_ar_pt,
   input  logic                cfg_ap_en,
   input  logic [IW-1:0]       cfg_ap_pt,
   input  logic                cfg_pin_reg,
   input  logic                cfg_fb_reg,
   input  logic [IW-1:0]       cfg_fold_pt,
   input  logic                cfg_oe_pin,
   input  logic                cfg_oe_inv,
   output logic                cas_out,
   output logic                fold_out,
   output logic                fb_out,
   output logic                pin_out,
   output logic                pin_oe
);

   if (NUM_PT < 3 || NUM_PT > 16) begin : g_bad_pt
      $error("NUM_PT must lie between 3 and 16");
   end
   if (NUM_GCLK < 1 || NUM_GCLK > 7) begin : g_bad_gclk
      $error("NUM_GCLK must lie between 1 and 7");
   end

   logic or_sum, comb_val, d_val, k_val;
   logic st_clk, st_ce, st_arst, st_apre, st_q;

   mc_steer #(.NUM_PT(NUM_PT), .HAS_CASCADE(HAS_CASCADE)) u_steer (
      .pt_in       (pt_in),
      .cas_in      (cas_in),
      .pin_in      (pin_in),
      .cfg_or_mask (cfg_or_mask),
      .cfg_cas_en  (cfg_cas_en),
      .cfg_xor_sel (cfg_xor_sel),
      .cfg_xor_pt  (cfg_xor_pt),
      .cfg_dsrc    (cfg_dsrc),
      .cfg_dpt     (cfg_dpt),
      .cfg_fold_pt (cfg_fold_pt),
      .or_sum      (or_sum),
      .comb_val    (comb_val),
      .d_val       (d_val),
      .k_val       (k_val),
      .fold_val    (fold_out)
   );

   mc_ctrl #(.NUM_PT(NUM_PT), .NUM_GCLK(NUM_GCLK)) u_ctrl (
      .pt_in       (pt_in),
      .gclk        (gclk),
      .gclr        (gclr),
      .cfg_clk_sel (cfg_clk_sel),
      .cfg_clk_pt  (cfg_clk_pt),
      .cfg_ce_en   (cfg_ce_en),
      .cfg_ce_pt   (cfg_ce_pt),
      .cfg_ar_sel  (cfg_ar_sel),
      .cfg_ar_pt   (cfg_ar_pt),
      .cfg_ap_en   (cfg_ap_en),
      .cfg_ap_pt   (cfg_ap_pt),
      .st_clk      (st_clk),
      .st_ce       (st_ce),
      .st_arst     (st_arst),
      .st_apre     (st_apre)
   );

   mc_store u_store (
      .st_clk   (st_clk),
      .st_ce    (st_ce),
      .st_arst  (st_arst),
      .st_apre  (st_apre),
      .cfg_mode (cfg_mode),
      .d_val    (d_val),
      .k_val    (k_val),
      .st_q     (st_q)
   );

   assign cas_out = or_sum;
   assign pin_out = cfg_pin_reg ? st_q : comb_val;
   assign fb_out  = cfg_fb_reg  ? st_q : comb_val;
   assign pin_oe  = goe[cfg_oe_pin] ^ cfg_oe_inv;

   logic on_gclk0;
   assign on_gclk0 = (cfg_clk_sel == '0);

   // R4
   d_load_chk: assert property (@(posedge gclk[0]) disable iff (st_arst || st_apre)
      (on_gclk0 && mode_e'(cfg_mode) == MODE_D && st_ce) |=> (st_q == $past(d_val)));

   // R4
   t_toggle_chk: assert property (@(posedge gclk[0]) disable iff (st_arst || st_apre)
      (on_gclk0 && mode_e'(cfg_mode) == MODE_T && st_ce && d_val) |=> (st_q != $past(st_q)));

   // R7
   ce_hold_chk: assert property (@(posedge gclk[0]) disable iff (st_arst || st_apre)
      (on_gclk0 && cfg_ce_en && !st_ce && mode_e'(cfg_mode) != MODE_LATCH) |=> $stable(st_q));

endmodule

// File: tb/mc_cell_test.sv
module mc_cell_test;

   logic       clk0 = 1'b0;
   logic       g1 = 1'b0, g2 = 1'b0;
   logic [4:0] pt_in = '0;
   logic       cas_in = 1'b0, gclr = 1'b1, pin_in = 1'b0;
   logic [1:0] goe = '0;
   logic [4:0] cfg_or_mask;
   logic       cfg_cas_en, cfg_ce_en, cfg_ap_en, cfg_pin_reg, cfg_fb_reg, cfg_oe_pin, cfg_oe_inv;
   logic [1:0] cfg_xor_sel, cfg_dsrc, cfg_clk_sel, cfg_ar_sel;
   logic [2:0] cfg_xor_pt, cfg_dpt, cfg_mode, cfg_clk_pt, cfg_ce_pt, cfg_ar_pt, cfg_ap_pt, cfg_fold_pt;
   logic       cas_out, fold_out, fb_out, pin_out, pin_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk0 = ~clk0;

   mc_cell uut (
      .pt_in(pt_in), .cas_in(cas_in), .gclk({g2, g1, clk0}), .gclr(gclr), .goe(goe),
      .pin_in(pin_in), .cfg_or_mask(cfg_or_mask), .cfg_cas_en(cfg_cas_en),
      .cfg_xor_sel(cfg_xor_sel), .cfg_xor_pt(cfg_xor_pt), .cfg_dsrc(cfg_dsrc),
      .cfg_dpt(cfg_dpt), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
      .cfg_clk_pt(cfg_clk_pt), .cfg_ce_en(cfg_ce_en), .cfg_ce_pt(cfg_ce_pt),
      .cfg_ar_sel(cfg_ar_sel), .cfg_ar_pt(cfg_ar_pt), .cfg_ap_en(cfg_ap_en),
      .cfg_ap_pt(cfg_ap_pt), .cfg_pin_reg(cfg_pin_reg), .cfg_fb_reg(cfg_fb_reg),
      .cfg_fold_pt(cfg_fold_pt), .cfg_oe_pin(cfg_oe_pin), .cfg_oe_inv(cfg_oe_inv),
      .cas_out(cas_out), .fold_out(fold_out), .fb_out(fb_out), .pin_out(pin_out),
      .pin_oe(pin_oe)
   );

   task automatic chk(input string req, input string what, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: %s got %b expected %b", req, what, got, exp);
      end
   endtask

   task automatic step;
      @(posedge clk0);
      #1;
   endtask

   task automatic at_low;
      @(negedge clk0);
      #1;
   endtask

   // clock-select changes happen while the clock is low, then one edge passes
   task automatic sel_clk(input logic [1:0] v);
      at_low;
      cfg_clk_sel = v;
      step;
   endtask

   task automatic defaults;
      cfg_or_mask = '0; cfg_cas_en = 0; cfg_xor_sel = 2'd0; cfg_xor_pt = 0;
      cfg_dsrc = 2'd2; cfg_dpt = 3'd1; cfg_mode = 3'd0; cfg_clk_sel = 2'd0;
      cfg_clk_pt = 3'd2; cfg_ce_en = 0; cfg_ce_pt = 3'd1; cfg_ar_sel = 2'd1;
      cfg_ar_pt = 3'd0; cfg_ap_en = 0; cfg_ap_pt = 3'd3; cfg_pin_reg = 1;
      cfg_fb_reg = 0; cfg_fold_pt = 3'd2; cfg_oe_pin = 0; cfg_oe_inv = 0;
      pt_in = '0; cas_in = 0; pin_in = 0;
   endtask

   task automatic restart;
      at_low;
      defaults;
      gclr = 1;
      step;
      gclr = 0;
   endtask

   task automatic test_or;
      cfg_or_mask = 5'b00101; pt_in = 5'b00010; #1;
      chk("R1", "unsteered term", cas_out, 1'b0);
      pt_in = 5'b00100; #1;
      chk("R1", "steered term", cas_out, 1'b1);
      pt_in = 5'b11010; #1;
      chk("R1", "all unsteered high", cas_out, 1'b0);
      pt_in = '0; cas_in = 1; #1;
      chk("R1", "cascade disabled", cas_out, 1'b0);
      cfg_cas_en = 1; #1;
      chk("R1", "cascade enabled", cas_out, 1'b1);
      cas_in = 0; cfg_cas_en = 0; cfg_or_mask = '0;
   endtask

   task automatic test_xor;
      cfg_pin_reg = 0; cfg_or_mask = 5'b00001; pt_in = 5'b00001;
      cfg_xor_sel = 2'd1; #1;
      chk("R2", "xor const one", pin_out, 1'b0);
      cfg_xor_sel = 2'd0; #1;
      chk("R2", "xor const zero", pin_out, 1'b1);
      cfg_xor_sel = 2'd2; cfg_xor_pt = 3'd4; pt_in = 5'b10001; #1;
      chk("R2", "xor term high", pin_out, 1'b0);
      pt_in = 5'b00001; #1;
      chk("R2", "xor term low", pin_out, 1'b1);
   endtask

   task automatic test_dsrc;
      restart;
      cfg_fb_reg = 1; pin_in = 1; step;
      chk("R3", "pin source high", pin_out, 1'b1);
      chk("R10", "registered feedback", fb_out, 1'b1);
      pin_in = 0; step;
      chk("R3", "pin source low", pin_out, 1'b0);
      cfg_dsrc = 2'd1; cfg_dpt = 3'd3; pt_in = 5'b01000; step;
      chk("R3", "term source", pin_out, 1'b1);
      cfg_dsrc = 2'd0; cfg_or_mask = 5'b00001; pt_in = '0; step;
      chk("R3", "xor source low", pin_out, 1'b0);
      cfg_xor_sel = 2'd1; step;
      chk("R3", "xor source inverted", pin_out, 1'b1);
   endtask

   task automatic test_modes;
      restart;
      cfg_mode = 3'd1; pin_in = 1; step;
      chk("R4", "T toggle 1", pin_out, 1'b1);
      step;
      chk("R4", "T toggle 2", pin_out, 1'b0);
      pin_in = 0; step;
      chk("R4", "T hold", pin_out, 1'b0);
      cfg_mode = 3'd2; pin_in = 1; pt_in = 5'b00000; step;
      chk("R4", "JK set", pin_out, 1'b1);
      pin_in = 0; pt_in = 5'b00010; step;
      chk("R4", "JK reset", pin_out, 1'b0);
      pin_in = 1; step;
      chk("R4", "JK toggle up", pin_out, 1'b1);
      step;
      chk("R4", "JK toggle down", pin_out, 1'b0);
      pin_in = 1; pt_in = '0; step;
      pin_in = 0; step;
      chk("R4", "JK hold", pin_out, 1'b1);
      cfg_mode = 3'd3; pt_in = 5'b00010; step;
      chk("R4", "SR reset", pin_out, 1'b0);
      pin_in = 1; pt_in = '0; step;
      chk("R4", "SR set", pin_out, 1'b1);
      pin_in = 0; step;
      chk("R4", "SR hold", pin_out, 1'b1);
      pin_in = 1; pt_in = 5'b00010; step;
      chk("R4", "SR both active clears", pin_out, 1'b0);
   endtask

   task automatic test_latch;
      restart;
      cfg_mode = 3'd4;
      sel_clk(2'd1);
      g1 = 1; pin_in = 1; #1;
      chk("R5", "transparent high", pin_out, 1'b1);
      pin_in = 0; #1;
      chk("R5", "transparent low", pin_out, 1'b0);
      pin_in = 1; #1;
      g1 = 0; #1;
      pin_in = 0; #1;
      chk("R5", "held while clock low", pin_out, 1'b1);
      step;
      chk("R5", "other clock ignored", pin_out, 1'b1);
   endtask

   task automatic test_clksel;
      restart;
      sel_clk(2'd1);
      pin_in = 1; step; step;
      chk("R6", "unselected clock ignored", pin_out, 1'b0);
      g1 = 1; #1;
      chk("R6", "selected global edge", pin_out, 1'b1);
      g1 = 0;
      sel_clk(2'd3);
      pin_in = 0; step;
      chk("R6", "no term edge", pin_out, 1'b1);
      pt_in = 5'b00100; #1;
      chk("R6", "term clock edge", pin_out, 1'b0);
      pt_in = '0;
      sel_clk(2'd0);
   endtask

   task automatic test_ce;
      restart;
      cfg_ce_en = 1; pin_in = 1; step;
      chk("R7", "enable low blocks edge", pin_out, 1'b0);
      step;
      chk("R7", "enable low second edge", pin_out, 1'b0);
      pt_in = 5'b00010; step;
      chk("R7", "enable high loads", pin_out, 1'b1);
      pt_in = '0; pin_in = 0; step;
      chk("R7", "enable low holds", pin_out, 1'b1);
      sel_clk(2'd3);
      pt_in = 5'b00100; #1;
      chk("R7", "enable ignored on term clock", pin_out, 1'b0);
      pt_in = '0;
      sel_clk(2'd0);
      cfg_ce_en = 0;
   endtask

   task automatic load_one;
      sel_clk(2'd0);
      pin_in = 1; step;
      sel_clk(2'd2);
   endtask

   task automatic test_ar;
      restart;
      cfg_ar_sel = 2'd2;
      load_one;
      chk("R8", "loaded before clear", pin_out, 1'b1);
      pt_in = 5'b00001; #1;
      chk("R8", "term clear", pin_out, 1'b0);
      pt_in = '0;
      load_one;
      gclr = 1; #1;
      chk("R8", "global clear ignored when term chosen", pin_out, 1'b1);
      gclr = 0;
      cfg_ar_sel = 2'd3; gclr = 1; #1;
      chk("R8", "either: global", pin_out, 1'b0);
      gclr = 0;
      load_one;
      pt_in = 5'b00001; #1;
      chk("R8", "either: term", pin_out, 1'b0);
      pt_in = '0; cfg_ar_sel = 2'd0;
      load_one;
      gclr = 1; pt_in = 5'b00001; #1;
      chk("R8", "clear off", pin_out, 1'b1);
      gclr = 0; pt_in = '0; cfg_ar_sel = 2'd1;
      sel_clk(2'd0);
   endtask

   task automatic test_ap;
      restart;
      sel_clk(2'd2);
      cfg_ap_en = 1; pt_in = 5'b01000; #1;
      chk("R9", "term preset", pin_out, 1'b1);
      pt_in = '0; #1;
      chk("R9", "preset hold", pin_out, 1'b1);
      gclr = 1; #1;
      pt_in = 5'b01000; #1;
      chk("R9", "clear beats preset", pin_out, 1'b0);
      pt_in = '0; gclr = 0; cfg_ap_en = 0; #1;
      chk("R9", "stays clear", pin_out, 1'b0);
      sel_clk(2'd0);
   endtask

   task automatic test_outsel;
      restart;
      sel_clk(2'd2);
      cfg_or_mask = 5'b00001; pt_in = 5'b00001;
      cfg_pin_reg = 0; cfg_fb_reg = 1; #1;
      chk("R10", "pin combinational", pin_out, 1'b1);
      chk("R10", "feedback registered", fb_out, 1'b0);
      cfg_pin_reg = 1; cfg_fb_reg = 0; #1;
      chk("R10", "pin registered", pin_out, 1'b0);
      chk("R10", "feedback combinational", fb_out, 1'b1);
      pt_in = '0; cfg_or_mask = '0;
      sel_clk(2'd0);
   endtask

   task automatic test_fold;
      pt_in = 5'b00100; #1;
      chk("R11", "fold of high term", fold_out, 1'b0);
      pt_in = 5'b11011; #1;
      chk("R11", "fold of low term", fold_out, 1'b1);
      pt_in = '0;
   endtask

   task automatic test_oe;
      cfg_oe_pin = 1; cfg_oe_inv = 0; goe = 2'b10; #1;
      chk("R12", "oe from second pin", pin_oe, 1'b1);
      goe = 2'b01; #1;
      chk("R12", "oe second pin low", pin_oe, 1'b0);
      cfg_oe_inv = 1; #1;
      chk("R12", "oe inverted", pin_oe, 1'b1);
      cfg_oe_pin = 0; cfg_oe_inv = 0; #1;
      chk("R12", "oe first pin", pin_oe, 1'b1);
   endtask

   initial begin
      defaults;
      gclr = 1;
      repeat (3) step;
      gclr = 0;
      step;
      chk("R8", "reset state pin", pin_out, 1'b0);
      chk("R12", "reset state oe", pin_oe, 1'b0);
      test_or;
      test_xor;
      test_dsrc;
      test_modes;
      test_latch;
      test_clksel;
      test_ce;
      test_ar;
      test_ap;
      test_outsel;
      test_fold;
      test_oe;
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run hung, got running expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule